// File: doc/BRIEF.md
# Protection Command-Set Entry Sequencer

This block decodes the stream of bus write cycles that reaches a byte-wide parallel flash device. It selects and tracks the protection command sets. In array-read mode it looks for a three-write unlock-and-entry pattern. The last write of that pattern carries a code, and the code picks one of five command sets: the one-time lock register, the password, the per-sector persistent protection bits, the global lock bit for those persistent bits, or the per-sector volatile protection bits. After entry the block stays in that set. Only a two-write exit pattern returns it to array-read mode.

While a set is active, the block recognises two-write commands inside it. A program command is a prefix write followed by an operand write. The persistent-bit set also has an erase-all command. Each decoded event produces a one-cycle strobe on the registered outputs. The strobe carries an opcode together with the address and data of the write that completed the event. The protection sub-blocks next to this one act on that strobe, and they read the current mode from a registered output. Write cycles may be separated by any number of idle cycles.

Top module: `prot_seq_top`

## Requirements
- R1: While reset is asserted and afterwards until a set is entered, `mode_o` is 0 (array read) and `cmd_valid_o` is 0, with `cmd_op_o` 0.
- R2: In read mode, three writes enter a set: address AAA with data AA, then address 555 with data 55, then address AAA with a set code. The codes map to `mode_o` as follows: 40→1 (lock register), 60→2 (password), C0→3 (persistent bits), 50→4 (persistent lock bit), E0→5 (volatile bits). Any other code enters nothing. The new mode appears on the clock edge that samples the third write. On that same edge there is a one-cycle strobe with `cmd_op_o`=1, and the strobe carries the third write's address and data.
- R3: For the persistent-bit set only, address 055 is also accepted in place of 555 on the second write. After a second write at 055, every other code enters nothing.
- R4: A write that does not match the next expected step of the entry pattern discards the partial sequence. That write is not reused as a first step, so decoding resumes from the first step with the following write.
- R5: Unlock, command and exit decoding compare only address bits [11:0] and data bits [7:0]. Higher address and data bits have no effect on whether a write matches.
- R6: Inside any set, a write with data 90 followed by a write with data 00 at any addresses returns `mode_o` to 0, with a strobe of `cmd_op_o`=4 on the edge of the second write. A write other than 00 after 90 cancels the exit, and that write is not reconsidered.
- R7: Inside a set, no write other than a completed exit changes `mode_o`. This includes a repeated entry pattern.
- R8: Inside any set, a write with data A0 followed by any write gives a strobe with `cmd_op_o`=2. The strobe carries the full address and data of the operand write. The operand write is consumed even when its data would otherwise start an exit.
- R9: In the persistent-bit set (mode 3) only, a write with data 80 followed by data 30 at an address whose bits [11:0] are 000 gives a strobe with `cmd_op_o`=3. In any other mode the 80 prefix is ignored. A 30 at any other address cancels the command.
- R10: `cmd_valid_o` is high for exactly one cycle per decoded event, and a cycle with `wr_en` low changes neither the mode nor the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronous to clk |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data, low byte decoded |
| mode_o | output | 3 | Active command set, 0 = array read |
| cmd_valid_o | output | 1 | One-cycle strobe for a decoded event |
| cmd_op_o | output | 3 | Opcode of the strobe: 1 enter, 2 program, 3 erase-all, 4 exit |
| cmd_addr_o | output | ADDR_W | Address of the write that completed the event |
| cmd_data_o | output | DATA_W | Data of the write that completed the event |

## Verification
One write can complete one command and also look like the start of another. The operand of a program command whose data is 90 is the case that matters: it must finish the program and must not arm an exit. The bench sends A0, then an operand of 90, then 00. It expects a program strobe carrying the 90 operand, and then no exit, with the mode unchanged. In the same way it sends a full entry pattern while a set is active, and expects that the pattern neither re-enters nor switches the set. Every third-write code is swept against both second-write addresses. This checks that set selection and the alternative-address rule resolve together with no spurious entry.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_LOCKREG = 3'd1,
    MODE_PASSWD  = 3'd2,
    MODE_PBITS   = 3'd3,
    MODE_PLOCK   = 3'd4,
    MODE_VBITS   = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_ENTER     = 3'd1,
    OP_PROGRAM   = 3'd2,
    OP_ERASE_ALL = 3'd3,
    OP_EXIT      = 3'd4
  } op_e;

  localparam logic [7:0] KEY_DATA_A   = 8'hAA;
  localparam logic [7:0] KEY_DATA_B   = 8'h55;
  localparam logic [7:0] PFX_PROGRAM  = 8'hA0;
  localparam logic [7:0] PFX_EXIT     = 8'h90;
  localparam logic [7:0] SFX_EXIT     = 8'h00;
  localparam logic [7:0] PFX_ERASE    = 8'h80;
  localparam logic [7:0] SFX_ERASE    = 8'h30;

  function automatic mode_e code_to_mode(input logic [7:0] code);
    case (code)
      8'h40:   return MODE_LOCKREG;
      8'h60:   return MODE_PASSWD;
      8'hC0:   return MODE_PBITS;
      8'h50:   return MODE_PLOCK;
      8'hE0:   return MODE_VBITS;
      default: return MODE_READ;
    endcase
  endfunction

endpackage

// File: rtl/prot_unlock_det.sv
module prot_unlock_det #(
  parameter int CMP_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 wr_en,
  input  logic [CMP_W-1:0]     addr_lo,
  input  logic [7:0]           data_lo,
  output logic                 enter_hit,
  output prot_seq_pkg::mode_e  enter_mode
);
  import prot_seq_pkg::*;

  localparam logic [CMP_W-1:0] ADDR_LONG  = CMP_W'(12'hAAA);
  localparam logic [CMP_W-1:0] ADDR_MID   = CMP_W'(12'h555);
  localparam logic [CMP_W-1:0] ADDR_SHORT = CMP_W'(12'h055);

  typedef enum logic [1:0] {ST_IDLE, ST_KEY1, ST_KEY2} st_e;

  st_e  st_q, st_d;
  logic short_q, short_d;
  logic st_en;

  assign st_en = wr_en | ~active;

  always_comb begin
    st_d       = st_q;
    short_d    = short_q;
    enter_hit  = 1'b0;
    enter_mode = code_to_mode(data_lo);
    if (!active) begin
      st_d    = ST_IDLE;
      short_d = 1'b0;
    end else if (wr_en) begin
      case (st_q)
        ST_IDLE: begin
          if (addr_lo == ADDR_LONG && data_lo == KEY_DATA_A) begin
            st_d    = ST_KEY1;
            short_d = 1'b0;
          end
        end
        ST_KEY1: begin
          st_d = ST_IDLE;
          if (data_lo == KEY_DATA_B) begin
            if (addr_lo == ADDR_MID) begin
              st_d    = ST_KEY2;
              short_d = 1'b0;
            end else if (addr_lo == ADDR_SHORT) begin
              st_d    = ST_KEY2;
              short_d = 1'b1;
            end
          end
        end
        ST_KEY2: begin
          st_d = ST_IDLE;
          if (addr_lo == ADDR_LONG && enter_mode != MODE_READ &&
              (!short_q || enter_mode == MODE_PBITS))
            enter_hit = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      short_q <= 1'b0;
    end else if (st_en) begin
      st_q    <= st_d;
      short_q <= short_d;
    end
  end

endmodule

// File: rtl/prot_cmd_dec.sv
module prot_cmd_dec #(
  parameter int CMP_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  prot_seq_pkg::mode_e  mode,
  input  logic                 wr_en,
  input  logic [CMP_W-1:0]     addr_lo,
  input  logic [7:0]           data_lo,
  output logic                 op_hit,
  output prot_seq_pkg::op_e    op
);
  import prot_seq_pkg::*;

  typedef enum logic [1:0] {PD_NONE, PD_PROG, PD_EXIT, PD_ERASE} pend_e;

  pend_e pend_q, pend_d;
  logic  pend_en;
  logic  in_set;

  assign in_set  = (mode != MODE_READ);
  assign pend_en = wr_en | ~in_set;

  always_comb begin
    pend_d = pend_q;
    op_hit = 1'b0;
    op     = OP_NONE;
    if (!in_set) begin
      pend_d = PD_NONE;
    end else if (wr_en) begin
      case (pend_q)
        PD_NONE: begin
          if (data_lo == PFX_PROGRAM)
            pend_d = PD_PROG;
          else if (data_lo == PFX_EXIT)
            pend_d = PD_EXIT;
          else if (data_lo == PFX_ERASE && mode == MODE_PBITS)
            pend_d = PD_ERASE;
        end
        PD_PROG: begin
          pend_d = PD_NONE;
          op_hit = 1'b1;
          op     = OP_PROGRAM;
        end
        PD_EXIT: begin
          pend_d = PD_NONE;
          if (data_lo == SFX_EXIT) begin
            op_hit = 1'b1;
            op     = OP_EXIT;
          end
        end
        PD_ERASE: begin
          pend_d = PD_NONE;
          if (data_lo == SFX_ERASE && addr_lo == '0) begin
            op_hit = 1'b1;
            op     = OP_ERASE_ALL;
          end
        end
        default: pend_d = PD_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= PD_NONE;
    else if (pend_en)
      pend_q <= pend_d;
  end

endmodule

// File: rtl/prot_seq_top.sv
module prot_seq_top #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [2:0]        mode_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  import prot_seq_pkg::*;

  localparam int BYTE_W = 8;

  logic [CMP_W-1:0]  addr_lo;
  logic [BYTE_W-1:0] data_lo;
  logic              enter_hit, op_hit;
  mode_e             enter_mode;
  op_e               dec_op;

  mode_e             mode_q, mode_d;
  logic              vld_q, vld_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] caddr_q;
  logic [DATA_W-1:0] cdata_q;

  assign addr_lo = wr_addr[CMP_W-1:0];
  assign data_lo = wr_data[BYTE_W-1:0];

  prot_unlock_det #(.CMP_W(CMP_W)) i_unlock (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (mode_q == MODE_READ),
    .wr_en      (wr_en),
    .addr_lo    (addr_lo),
    .data_lo    (data_lo),
    .enter_hit  (enter_hit),
    .enter_mode (enter_mode)
  );

  prot_cmd_dec #(.CMP_W(CMP_W)) i_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .wr_en   (wr_en),
    .addr_lo (addr_lo),
    .data_lo (data_lo),
    .op_hit  (op_hit),
    .op      (dec_op)
  );

  always_comb begin
    mode_d = mode_q;
    vld_d  = 1'b0;
    op_d   = OP_NONE;
    if (enter_hit) begin
      mode_d = enter_mode;
      vld_d  = 1'b1;
      op_d   = OP_ENTER;
    end else if (op_hit) begin
      vld_d = 1'b1;
      op_d  = dec_op;
      if (dec_op == OP_EXIT)
        mode_d = MODE_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_READ;
      vld_q   <= 1'b0;
      op_q    <= OP_NONE;
      caddr_q <= '0;
      cdata_q <= '0;
    end else begin
      vld_q <= vld_d;
      op_q  <= op_d;
      if (vld_d) begin
        mode_q  <= mode_d;
        caddr_q <= wr_addr;
        cdata_q <= wr_data;
      end
    end
  end

  assign mode_o      = mode_q;
  assign cmd_valid_o = vld_q;
  assign cmd_op_o    = op_q;
  assign cmd_addr_o  = caddr_q;
  assign cmd_data_o  = cdata_q;

endmodule

// File: rtl/prot_seq_chk.sv
module prot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] mode_o,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_op_o
);

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!cmd_valid_o && $stable(mode_o)));

  p_mode_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |->
      (cmd_valid_o && (cmd_op_o == 3'd1 || cmd_op_o == 3'd4)));

  p_enter_from_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_op_o == 3'd1) |-> ($past(mode_o) == 3'd0 && mode_o != 3'd0));

  p_exit_to_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_op_o == 3'd4) |-> (mode_o == 3'd0 && $past(mode_o) != 3'd0));

  p_erase_scope_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_op_o == 3'd3) |-> mode_o == 3'd3);

  p_quiet_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_o |-> cmd_op_o == 3'd0);

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 3'd5);

endmodule

bind prot_seq_top prot_seq_chk i_prot_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .mode_o      (mode_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o)
);

// File: tb/test_prot_seq_top.sv
module test_prot_seq_top;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [2:0]    mode_o;
  logic          cmd_valid_o;
  logic [2:0]    cmd_op_o;
  logic [AW-1:0] cmd_addr_o;
  logic [DW-1:0] cmd_data_o;

  int total = 0;
  int bad   = 0;

  prot_seq_top #(.ADDR_W(AW), .DATA_W(DW), .CMP_W(12)) i_prot_seq_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_o(mode_o), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic enter(input logic [7:0] code);
    wr(20'h00AAA, 16'h00AA);
    wr(20'h00555, 16'h0055);
    wr(20'h00AAA, {8'h00, code});
  endtask

  task automatic leave();
    wr(20'h00001, 16'h0090);
    wr(20'h00002, 16'h0000);
  endtask

  function automatic logic [2:0] exp_mode(input logic [7:0] c);
    case (c)
      8'h40: return 3'd1;
      8'h60: return 3'd2;
      8'hC0: return 3'd3;
      8'h50: return 3'd4;
      8'hE0: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    chk(mode_o == 3'd0, "R1 mode in reset", 32'(mode_o), 0);
    chk(cmd_valid_o == 1'b0, "R1 valid in reset", 32'(cmd_valid_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mode_o == 3'd0 && cmd_op_o == 3'd0, "R1 after reset", 32'({mode_o, cmd_op_o}), 0);

    // R2 R3 R5: sweep every code with both second-cycle addresses, upper bits noisy
    for (int c = 0; c < 256; c++) begin
      for (int alt = 0; alt < 2; alt++) begin
        logic [2:0] em;
        logic [DW-1:0] d3;
        em = exp_mode(8'(c));
        if (alt == 1 && em != 3'd3) em = 3'd0;
        d3 = {8'(c ^ 8'h3C), 8'(c)};
        wr({8'(c), 12'hAAA}, {8'(~c), 8'hAA});
        wr({8'(c + 1), (alt == 1) ? 12'h055 : 12'h555}, {8'(c), 8'h55});
        wr({8'(255 - c), 12'hAAA}, d3);
        chk(mode_o == em, alt ? "R3 mode after short key" : "R2 mode after entry", 32'(mode_o), 32'(em));
        chk(cmd_valid_o == (em != 3'd0), "R2 entry strobe", 32'(cmd_valid_o), 32'(em != 3'd0));
        if (em != 3'd0) begin
          chk(cmd_op_o == 3'd1, "R2 entry opcode", 32'(cmd_op_o), 1);
          chk(cmd_data_o == d3, "R5 entry data full width", 32'(cmd_data_o), 32'(d3));
          @(negedge clk);
          chk(cmd_valid_o == 1'b0, "R10 strobe one cycle", 32'(cmd_valid_o), 0);
          wr({8'(c), 12'h123}, {8'(c), 8'h90});
          chk(mode_o == em && !cmd_valid_o, "R6 half exit", 32'(mode_o), 32'(em));
          wr({8'(c), 12'h456}, {8'(~c), 8'h00});
          chk(mode_o == 3'd0, "R6 exit mode", 32'(mode_o), 0);
          chk(cmd_valid_o && cmd_op_o == 3'd4, "R6 exit strobe", 32'(cmd_op_o), 4);
        end
      end
    end

    // R4: broken step discards, breaking write not reused
    wr(20'h00AAA, 16'h00AA);
    wr(20'h00555, 16'h0056);
    wr(20'h00555, 16'h0055);
    wr(20'h00AAA, 16'h0040);
    chk(mode_o == 3'd0 && !cmd_valid_o, "R4 bad data breaks", 32'(mode_o), 0);
    wr(20'h00AAA, 16'h00AA);
    wr(20'h00AAA, 16'h00AA);
    wr(20'h00555, 16'h0055);
    wr(20'h00AAA, 16'h0040);
    chk(mode_o == 3'd0, "R4 breaking write not reused", 32'(mode_o), 0);
    enter(8'h40);
    chk(mode_o == 3'd1, "R4 recovery entry", 32'(mode_o), 1);
    leave();

    // R7 R8 R9 R10 in password set
    enter(8'h60);
    chk(mode_o == 3'd2, "R2 password entry", 32'(mode_o), 2);
    enter(8'hC0);
    chk(mode_o == 3'd2 && !cmd_valid_o, "R7 re-entry ignored", 32'(mode_o), 2);
    wr(20'h00003, 16'h0080);
    wr(20'h00000, 16'h0030);
    chk(!cmd_valid_o, "R9 erase outside persistent set", 32'(cmd_valid_o), 0);
    wr(20'h00003, 16'h00A0);
    repeat (3) @(negedge clk);
    chk(mode_o == 3'd2 && !cmd_valid_o, "R10 idle cycles", 32'(cmd_valid_o), 0);
    wr(20'hBC007, 16'h1290);
    chk(cmd_valid_o && cmd_op_o == 3'd2, "R8 program strobe", 32'(cmd_op_o), 2);
    chk(cmd_addr_o == 20'hBC007 && cmd_data_o == 16'h1290, "R8 operand", 32'(cmd_data_o), 32'h1290);
    wr(20'h00004, 16'h0000);
    chk(mode_o == 3'd2 && !cmd_valid_o, "R8 operand not an exit prefix", 32'(mode_o), 2);
    wr(20'h00004, 16'h0090);
    wr(20'h00004, 16'h0012);
    wr(20'h00004, 16'h0000);
    chk(mode_o == 3'd2, "R6 cancelled exit", 32'(mode_o), 2);
    leave();
    chk(mode_o == 3'd0, "R6 exit from password", 32'(mode_o), 0);

    // R9 in persistent set
    enter(8'hC0);
    wr(20'h00009, 16'h0080);
    wr(20'h50000, 16'hFF30);
    chk(cmd_valid_o && cmd_op_o == 3'd3, "R9 erase-all strobe", 32'(cmd_op_o), 3);
    wr(20'h00009, 16'h0080);
    wr(20'h00001, 16'h0030);
    chk(!cmd_valid_o, "R9 erase wrong address", 32'(cmd_valid_o), 0);
    wr(20'h00009, 16'h00A0);
    wr(20'hA5000, 16'h0000);
    chk(cmd_valid_o && cmd_op_o == 3'd2 && cmd_addr_o == 20'hA5000, "R8 sector program", 32'(cmd_addr_o), 32'hA5000);
    leave();
    chk(mode_o == 3'd0, "R6 exit from persistent", 32'(mode_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule